// File: doc/BRIEF.md
# Packed Register Renaming with Read Coalescing

This block maps architectural registers onto a physical register file in which every entry offers four byte slots per lane, so that two to four narrow values can share one entry. On each register write it classifies the value as 1, 2 or 4 bytes wide, taking the widest lane. When the register has no home yet, or its slot is now too small, the block gives it an aligned slot run and records the entry, offset and width in a renaming table.

Before a kernel runs, a configuration port loads a table of exclusive register pairs that are often read together. When one register of a pair is allocated and its partner already lives in an entry with a suitable free aligned run, the register is placed in that entry. In every other case allocation is first-fit. For an instruction with two source registers, the block reports one cycle later whether both operands can be served by a single physical read. It also gives the entry address of each operand and the offset and width class of each operand's slot.

Top module: `packed_rename_unit`

## Requirements
- R1: After reset no register is mapped, and a read of any two registers reports coalesce 0, entries 0, offsets 0 and width code 0 (unmapped).
- R2: Width codes are 1 = one byte, 2 = two bytes, 3 = four bytes. A written value gets code 1 if every 32-bit lane is below 256 (unsigned), code 2 if every lane is below 65536, and code 3 otherwise.
- R3: A slot of 2 bytes starts at offset 0 or 2, and a 4-byte slot starts at offset 0. The slot runs of two different mapped registers never overlap.
- R4: First-fit: with no usable pair hint, a register goes to the lowest-numbered entry that has a free aligned run of its size, at the lowest such offset in that entry.
- R5: If the written register has a pair hint, and its partner is mapped and has a free aligned run of the needed size in the partner's entry, then the register is placed in the partner's entry.
- R6: If the partner's entry has no such run, or the partner is unmapped, the register is placed by first-fit.
- R7: Rewriting a mapped register with a value whose width code is not larger than its recorded code leaves its entry, offset and code unchanged.
- R8: Rewriting with a wider value first frees the register's old slots and then reallocates it. Its own freed bytes are counted as free, and the new mapping is seen by the next read.
- R9: Coalesce is 1 exactly when both source registers are mapped and their entries are equal. This includes the case of the same register given twice.
- R10: Mapped sources in different entries give coalesce 0 and the two distinct entry addresses.
- R11: Read results and rd_valid appear one clock after rd_en, and rd_valid is 0 in a cycle that follows no request.
- R12: Pair hints are written through the hint port only while no write or read is requested. A register whose hint is disabled is treated as unpaired.
- R13: When a read and a write are requested in the same cycle, the read reports the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_we | input | 1 | Write one pair-hint record |
| hint_reg | input | AREG_W | Register whose hint is written |
| hint_partner | input | AREG_W | Partner register |
| hint_en | input | 1 | 1 = pair valid, 0 = unpaired |
| wr_en | input | 1 | Register write request |
| wr_reg | input | AREG_W | Destination register |
| wr_data | input | 32*LANES | Value written, one 32-bit word per lane |
| rd_en | input | 1 | Two-source read request |
| rd_reg_a | input | AREG_W | First source register |
| rd_reg_b | input | AREG_W | Second source register |
| rd_valid | output | 1 | Read results valid |
| rd_coalesce | output | 1 | Both sources served by one physical read |
| rd_entry_a | output | ENT_W | Physical entry of source A |
| rd_entry_b | output | ENT_W | Physical entry of source B |
| rd_off_a | output | 2 | Byte offset of source A |
| rd_off_b | output | 2 | Byte offset of source B |
| rd_wcls_a | output | 2 | Width code of source A |
| rd_wcls_b | output | 2 | Width code of source B |

## Verification
Writes have no output of their own; their effect is due in the table at the clock edge that takes the write. It is therefore observed through a read issued in a later cycle, or in the same cycle to test R13. Read results are registered once, so the bench drives a request at the falling edge and lets one rising edge pass. It then samples all outputs at the next falling edge against a bench model updated only after that comparison. At the following falling edge it checks that rd_valid has dropped again.

// File: rtl/prc_pkg.sv
package prc_pkg;

   typedef enum logic [1:0] {
      WC_NONE = 2'd0,
      WC_B1   = 2'd1,
      WC_B2   = 2'd2,
      WC_B4   = 2'd3
   } wclass_e;

   localparam int SLOTS = 4;

   // byte-slot mask covered by a value of class w starting at offset o
   function automatic logic [SLOTS-1:0] span_mask(wclass_e w, logic [1:0] o);
      case (w)
         WC_B1:   span_mask = 4'b0001 << o;
         WC_B2:   span_mask = 4'b0011 << o;
         WC_B4:   span_mask = 4'b1111;
         default: span_mask = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/prc_width_class.sv
module prc_width_class
   import prc_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 32
) (
   input  logic [LANES*LANE_W-1:0] data,
   output wclass_e                 cls
);
   generate
      if (LANE_W != 32) begin : g_bad_lane
         $error("prc_width_class: LANE_W must be 32");
      end
   endgenerate

   logic need_b2, need_b4;

   always_comb begin
      need_b2 = 1'b0;
      need_b4 = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if (data[l*LANE_W+8  +: 24] != '0) need_b2 = 1'b1;
         if (data[l*LANE_W+16 +: 16] != '0) need_b4 = 1'b1;
      end
      cls = need_b4 ? WC_B4 : (need_b2 ? WC_B2 : WC_B1);
   end
endmodule

// File: rtl/prc_slot_fit.sv
module prc_slot_fit
   import prc_pkg::*;
(
   input  logic [SLOTS-1:0] occ,
   input  wclass_e          cls,
   output logic             found,
   output logic [1:0]       off
);
   always_comb begin
      found = 1'b0;
      off   = 2'd0;
      for (int o = SLOTS-1; o >= 0; o--) begin
         logic aligned;
         case (cls)
            WC_B1:   aligned = 1'b1;
            WC_B2:   aligned = (o % 2) == 0;
            WC_B4:   aligned = (o == 0);
            default: aligned = 1'b0;
         endcase
         if (aligned && ((occ & span_mask(cls, 2'(o))) == '0)) begin
            found = 1'b1;
            off   = 2'(o);
         end
      end
   end
endmodule

// File: rtl/prc_read_merge.sv
module prc_read_merge
   import prc_pkg::*;
#(
   parameter int ENT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             a_v,
   input  logic [ENT_W-1:0] a_e,
   input  logic [1:0]       a_o,
   input  wclass_e          a_c,
   input  logic             b_v,
   input  logic [ENT_W-1:0] b_e,
   input  logic [1:0]       b_o,
   input  wclass_e          b_c,
   output logic             rd_valid,
   output logic             rd_coalesce,
   output logic [ENT_W-1:0] rd_entry_a,
   output logic [ENT_W-1:0] rd_entry_b,
   output logic [1:0]       rd_off_a,
   output logic [1:0]       rd_off_b,
   output logic [1:0]       rd_wcls_a,
   output logic [1:0]       rd_wcls_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_coalesce <= 1'b0;
         rd_entry_a  <= '0;
         rd_entry_b  <= '0;
         rd_off_a    <= '0;
         rd_off_b    <= '0;
         rd_wcls_a   <= '0;
         rd_wcls_b   <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_coalesce <= a_v && b_v && (a_e == b_e);
            rd_entry_a  <= a_e;
            rd_entry_b  <= b_e;
            rd_off_a    <= a_o;
            rd_off_b    <= b_o;
            rd_wcls_a   <= a_c;
            rd_wcls_b   <= b_c;
         end
      end
   end

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);                                               // R11
   AST_RD_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);                                             // R11
   AST_COAL_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_coalesce |-> (rd_entry_a == rd_entry_b) && (rd_wcls_a != 2'd0)); // R9
endmodule

// File: rtl/packed_rename_unit.sv
module packed_rename_unit
   import prc_pkg::*;
#(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 8,
   parameter int LANES    = 4,
   localparam int AREG_W  = $clog2(NUM_ARCH),
   localparam int ENT_W   = $clog2(NUM_PHYS),
   localparam int DATA_W  = LANES * 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hint_we,
   input  logic [AREG_W-1:0] hint_reg,
   input  logic [AREG_W-1:0] hint_partner,
   input  logic              hint_en,
   input  logic              wr_en,
   input  logic [AREG_W-1:0] wr_reg,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AREG_W-1:0] rd_reg_a,
   input  logic [AREG_W-1:0] rd_reg_b,
   output logic              rd_valid,
   output logic              rd_coalesce,
   output logic [ENT_W-1:0]  rd_entry_a,
   output logic [ENT_W-1:0]  rd_entry_b,
   output logic [1:0]        rd_off_a,
   output logic [1:0]        rd_off_b,
   output logic [1:0]        rd_wcls_a,
   output logic [1:0]        rd_wcls_b
);
   generate
      if ((1 << AREG_W) != NUM_ARCH || NUM_ARCH < 2) begin : g_bad_arch
         $error("packed_rename_unit: NUM_ARCH must be a power of two >= 2");
      end
      if ((1 << ENT_W) != NUM_PHYS || NUM_PHYS < NUM_ARCH) begin : g_bad_phys
         $error("packed_rename_unit: NUM_PHYS must be a power of two >= NUM_ARCH");
      end
   endgenerate

   // renaming table and pair hints
   logic              map_v [NUM_ARCH];
   logic [ENT_W-1:0]  map_e [NUM_ARCH];
   logic [1:0]        map_o [NUM_ARCH];
   wclass_e           map_c [NUM_ARCH];
   logic              hint_v [NUM_ARCH];
   logic [AREG_W-1:0] hint_p [NUM_ARCH];

   // width of the incoming value
   wclass_e wcls_new;
   prc_width_class #(.LANES(LANES), .LANE_W(32)) u_wcls (
      .data (wr_data),
      .cls  (wcls_new)
   );

   // occupancy derived from the table, with the destination's own slots freed
   logic [SLOTS-1:0] occ [NUM_PHYS];
   always_comb begin
      for (int e = 0; e < NUM_PHYS; e++) occ[e] = '0;
      for (int r = 0; r < NUM_ARCH; r++) begin
         if (map_v[r] && (AREG_W'(r) != wr_reg))
            occ[map_e[r]] = occ[map_e[r]] | span_mask(map_c[r], map_o[r]);
      end
   end

   logic [NUM_PHYS-1:0] fit_ok;
   logic [1:0]          fit_off [NUM_PHYS];
   for (genvar e = 0; e < NUM_PHYS; e++) begin : g_fit
      prc_slot_fit u_fit (
         .occ   (occ[e]),
         .cls   (wcls_new),
         .found (fit_ok[e]),
         .off   (fit_off[e])
      );
   end

   // first-fit entry search
   logic             ff_found;
   logic [ENT_W-1:0] ff_e;
   always_comb begin
      ff_found = 1'b0;
      ff_e     = '0;
      for (int e = NUM_PHYS-1; e >= 0; e--) begin
         if (fit_ok[e]) begin
            ff_found = 1'b1;
            ff_e     = ENT_W'(e);
         end
      end
   end

   // pair preference
   logic [AREG_W-1:0] pr;
   logic [ENT_W-1:0]  pe;
   logic              pair_ok;
   assign pr      = hint_p[wr_reg];
   assign pe      = map_e[pr];
   assign pair_ok = hint_v[wr_reg] && map_v[pr] && (pr != wr_reg) && fit_ok[pe];

   logic             need_realloc, alloc_found;
   logic [ENT_W-1:0] alloc_e;
   logic [1:0]       alloc_o;
   assign need_realloc = !map_v[wr_reg] || (wcls_new > map_c[wr_reg]);
   assign alloc_e      = pair_ok ? pe : ff_e;
   assign alloc_o      = fit_off[alloc_e];
   assign alloc_found  = pair_ok || ff_found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_ARCH; r++) begin
            map_v[r]  <= 1'b0;
            map_e[r]  <= '0;
            map_o[r]  <= '0;
            map_c[r]  <= WC_NONE;
            hint_v[r] <= 1'b0;
            hint_p[r] <= '0;
         end
      end else begin
         if (hint_we) begin
            hint_v[hint_reg] <= hint_en;
            hint_p[hint_reg] <= hint_partner;
         end
         if (wr_en && need_realloc && alloc_found) begin
            map_v[wr_reg] <= 1'b1;
            map_e[wr_reg] <= alloc_e;
            map_o[wr_reg] <= alloc_o;
            map_c[wr_reg] <= wcls_new;
         end
      end
   end

   prc_read_merge #(.ENT_W(ENT_W)) u_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (rd_en),
      .a_v         (map_v[rd_reg_a]),
      .a_e         (map_e[rd_reg_a]),
      .a_o         (map_o[rd_reg_a]),
      .a_c         (map_c[rd_reg_a]),
      .b_v         (map_v[rd_reg_b]),
      .b_e         (map_e[rd_reg_b]),
      .b_o         (map_o[rd_reg_b]),
      .b_c         (map_c[rd_reg_b]),
      .rd_valid    (rd_valid),
      .rd_coalesce (rd_coalesce),
      .rd_entry_a  (rd_entry_a),
      .rd_entry_b  (rd_entry_b),
      .rd_off_a    (rd_off_a),
      .rd_off_b    (rd_off_b),
      .rd_wcls_a   (rd_wcls_a),
      .rd_wcls_b   (rd_wcls_b)
   );

   AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      hint_we |-> !wr_en && !rd_en);                                     // R12
   AST_ALLOC_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && need_realloc |-> alloc_found);                            // R3
   AST_ALLOC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && need_realloc |-> (wcls_new == WC_B1) ||
                                (wcls_new == WC_B2 && !alloc_o[0]) ||
                                (wcls_new == WC_B4 && alloc_o == 2'd0)); // R3
   AST_PAIR_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && need_realloc && pair_ok |=> map_e[$past(wr_reg)] == $past(pe)); // R5
   AST_KEEP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !need_realloc |=> (map_e[$past(wr_reg)] == $past(map_e[wr_reg])) &&
                                 (map_o[$past(wr_reg)] == $past(map_o[wr_reg]))); // R7
endmodule

// File: tb/packed_rename_unit_bench.sv
`timescale 1ns/1ps
module packed_rename_unit_bench;
   localparam int NA = 8, NP = 8, LN = 4;
   localparam int AW = $clog2(NA), EW = $clog2(NP), DW = LN*32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hint_we = 0, hint_en = 0, wr_en = 0, rd_en = 0;
   logic [AW-1:0] hint_reg = '0, hint_partner = '0, wr_reg = '0, rd_reg_a = '0, rd_reg_b = '0;
   logic [DW-1:0] wr_data = '0;
   logic rd_valid, rd_coalesce;
   logic [EW-1:0] rd_entry_a, rd_entry_b;
   logic [1:0] rd_off_a, rd_off_b, rd_wcls_a, rd_wcls_b;

   always #2.5 clk = ~clk;

   packed_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .LANES(LN)) u_packed_rename_unit (
      .clk(clk), .rst_n(rst_n), .hint_we(hint_we), .hint_reg(hint_reg),
      .hint_partner(hint_partner), .hint_en(hint_en), .wr_en(wr_en), .wr_reg(wr_reg),
      .wr_data(wr_data), .rd_en(rd_en), .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b),
      .rd_valid(rd_valid), .rd_coalesce(rd_coalesce), .rd_entry_a(rd_entry_a),
      .rd_entry_b(rd_entry_b), .rd_off_a(rd_off_a), .rd_off_b(rd_off_b),
      .rd_wcls_a(rd_wcls_a), .rd_wcls_b(rd_wcls_b));

   int checks = 0, failures = 0;
   bit finished = 0;

   // bench model of the renaming table
   bit m_v [NA];
   int m_e [NA], m_o [NA], m_c [NA];
   bit h_v [NA];
   int h_p [NA];

   function automatic int cls_of(logic [DW-1:0] d);
      int c = 1;
      for (int l = 0; l < LN; l++) begin
         int unsigned w = d[l*32 +: 32];
         if (w >= 65536) c = 3;
         else if (w >= 256 && c < 2) c = 2;
      end
      return c;
   endfunction

   function automatic int size_of(int c);
      return (c == 3) ? 4 : c;
   endfunction

   function automatic int occ_of(int e, int skip);
      int m = 0;
      for (int r = 0; r < NA; r++)
         if (m_v[r] && r != skip && m_e[r] == e)
            m |= ((1 << size_of(m_c[r])) - 1) << m_o[r];
      return m;
   endfunction

   function automatic int fit_off(int occ, int c);
      int s = size_of(c);
      for (int o = 0; o < 4; o += s)
         if ((occ & (((1 << s) - 1) << o)) == 0) return o;
      return -1;
   endfunction

   function automatic void model_write(int r, logic [DW-1:0] d);
      int c = cls_of(d);
      int p = h_p[r];
      if (m_v[r] && c <= m_c[r]) return;
      if (h_v[r] && p != r && m_v[p] && fit_off(occ_of(m_e[p], r), c) >= 0) begin
         m_o[r] = fit_off(occ_of(m_e[p], r), c);
         m_e[r] = m_e[p];
      end else begin
         for (int e = 0; e < NP; e++) begin
            if (fit_off(occ_of(e, r), c) >= 0) begin
               m_o[r] = fit_off(occ_of(e, r), c);
               m_e[r] = e;
               break;
            end
         end
      end
      m_c[r] = c;
      m_v[r] = 1;
   endfunction

   function automatic logic [DW-1:0] make_val(int c);
      logic [DW-1:0] d;
      for (int l = 0; l < LN; l++) begin
         int unsigned w = $urandom;
         if (c == 1) w = w % 256;
         else if (c == 2) w = w % 65536;
         d[l*32 +: 32] = w;
      end
      return d;
   endfunction

   function automatic logic [DW-1:0] splat(int unsigned v);
      logic [DW-1:0] d;
      for (int l = 0; l < LN; l++) d[l*32 +: 32] = v;
      return d;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_hint(int r, int p, bit en);
      @(negedge clk);
      hint_we = 1; hint_reg = AW'(r); hint_partner = AW'(p); hint_en = en;
      @(negedge clk);
      hint_we = 0;
      h_v[r] = en; h_p[r] = p;
   endtask

   task automatic do_write(int r, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_reg = AW'(r); wr_data = d;
      @(negedge clk);
      wr_en = 0;
      model_write(r, d);
   endtask

   // read, optionally with a same-cycle write; model consulted before the write
   task automatic do_read(string tag, int a, int b, bit with_wr, int wr, logic [DW-1:0] d);
      logic [31:0] exp, act;
      @(negedge clk);
      rd_en = 1; rd_reg_a = AW'(a); rd_reg_b = AW'(b);
      if (with_wr) begin wr_en = 1; wr_reg = AW'(wr); wr_data = d; end
      exp = {18'd0,
             1'b1,
             1'(m_v[a] && m_v[b] && m_e[a] == m_e[b]),
             3'(m_v[a] ? m_e[a] : 0), 3'(m_v[b] ? m_e[b] : 0),
             2'(m_v[a] ? m_o[a] : 0), 2'(m_v[b] ? m_o[b] : 0),
             2'(m_v[a] ? m_c[a] : 0), 2'(m_v[b] ? m_c[b] : 0)};
      @(negedge clk);
      rd_en = 0; wr_en = 0;
      act = {18'd0, rd_valid, rd_coalesce, 3'(rd_entry_a), 3'(rd_entry_b),
             rd_off_a, rd_off_b, rd_wcls_a, rd_wcls_b};
      check(tag, act, exp);
      if (with_wr) model_write(wr, d);
      @(negedge clk);
      check("R11 rd_valid idle", {31'd0, rd_valid}, 32'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] z = '0;
      void'($urandom(32'd4711));
      for (int r = 0; r < NA; r++) begin
         m_v[r] = 0; m_e[r] = 0; m_o[r] = 0; m_c[r] = 0; h_v[r] = 0; h_p[r] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      do_read("R1 reset state", 0, 1, 0, 0, z);
      cfg_hint(4, 5, 1); cfg_hint(5, 4, 1);
      cfg_hint(6, 7, 1); cfg_hint(7, 6, 1);
      cfg_hint(2, 3, 0);                       // R12 disabled hint
      do_write(0, splat(32'h12));
      do_write(1, splat(32'h34));
      do_read("R4 R12 first fit unpaired e0 o0/o1", 0, 1, 0, 0, z);
      check("R4 expected layout r1 at e0 o1", {30'd0, 2'(m_o[1])}, 32'd1);
      do_write(2, {32'h0, 32'h1234, 64'h0});
      do_read("R2 R3 two-byte class at o2", 0, 2, 0, 0, z);
      do_write(3, splat(32'h12345678));
      do_read("R10 different entries", 0, 3, 0, 0, z);
      do_write(4, splat(32'h7));
      do_write(5, splat(32'h0abc));
      do_read("R5 pair placed in partner entry", 4, 5, 0, 0, z);
      check("R5 model pair same entry", 32'(m_e[4] == m_e[5]), 32'd1);
      do_write(6, splat(32'hdeadbeef));
      do_write(7, splat(32'h1));
      do_read("R6 partner full falls back to first fit", 6, 7, 0, 0, z);
      do_write(0, splat(32'h5));
      do_read("R7 narrow rewrite keeps slot", 0, 1, 0, 0, z);
      do_write(1, splat(32'h10000));
      do_read("R8 wider rewrite reallocates", 1, 0, 0, 0, z);
      do_read("R9 same register twice", 1, 1, 0, 0, z);
      do_read("R13 read sees pre-write table", 0, 2, 1, 0, splat(32'h300));
      do_read("R8 R3 own slots freed, realloc", 0, 2, 0, 0, z);
      for (int i = 0; i < 600; i++) begin
         int op = $urandom % 4;
         int r = $urandom % NA;
         logic [DW-1:0] d = make_val(1 + ($urandom % 3));
         if (op == 0) do_write(r, d);
         else if (op == 1) do_read("R9 R10 random read", $urandom % NA, $urandom % NA, 0, 0, z);
         else if (op == 2) do_read("R13 random read with write", $urandom % NA, $urandom % NA, 1, r, d);
         else begin
            do_write(r, d);
            do_read("R3 R4 R5 R8 random after write", r, h_p[r], 0, 0, z);
         end
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule